// File: doc/BRIEF.md
# Serial Controller Register Block with Interrupt Identification

This block is the processor-facing register file of a PC-style asynchronous serial controller. A synchronous port with a 3-bit address, a write strobe and a read strobe reaches eight byte-wide locations. The block holds the interrupt enable, line control, modem control, scratch and 16-bit baud divisor registers. It assembles the line-status and modem-status bytes from flags supplied by the receive queue, the transmitter and the modem pins. It ranks the pending interrupt causes, reports the winner as an identification code and drives one interrupt request line.

The receive queue, the transmitter and the bit-level serial logic live outside. They send their status in as level flags or one-cycle event pulses, and the block sends their configuration fields out as plain pins. A data transfer between this block and those units is a single-cycle strobe: `tx_load` carries the written byte for one cycle, and `rx_pop` marks the cycle in which the receive byte was read. The block applies no back-pressure. A strobe is final, and the neighbour must accept the byte or supply it in that cycle. Read data is combinational from the address. Every side effect of a read (clearing a flag, popping a byte) takes effect at the clock edge that ends the read cycle.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the enable, line control, modem control and scratch registers read 0x00, the identification location (address 2) reads 0x01, and `irq` is low.
- R2: Addresses 1 (enable, bits 3:0 kept, bits 7:4 read 0), 3 (line control, 8 bits), 4 (modem control, bits 4:0 kept) and 7 (scratch) read back what was last written.
- R3: While line-control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the divisor high byte. `divisor` shows {high, low}. The data path and the enable register are not touched.
- R4: With line-control bit 7 at 0, a write to address 0 pulses `tx_load` for that cycle with `tx_data` equal to the written byte. A read returns `rx_data` and pulses `rx_pop`.
- R5: A write to address 2 stores bit 0 as `fifo_en` and bits 7:6 as `rx_trig`, and gives one-cycle pulses on `rx_fifo_clr` (bit 1) and `tx_fifo_clr` (bit 2). Identification bits 7:6 read 11 while `fifo_en` is 1.
- R6: Line status (address 5) is bit0 `rx_ready`, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit5 `thr_empty`, bit6 `tx_idle`, bit7 `rx_fifo_err`. Bits 4:1 latch their event pulses and clear when the location is read.
- R7: Modem status (address 6) bits 7:4 are the current DCD, RI, DSR and CTS levels, from bit 7 down to bit 4. Bits 3:0 latch changes: bit0 CTS changed, bit1 DSR changed, bit2 RI fell from 1 to 0, bit3 DCD changed. Reading the location clears bits 3:0.
- R8: Modem-control bit 4 selects loopback. In loopback, CTS follows bit 1, DSR follows bit 0, RI follows bit 2 and DCD follows bit 3, and `dtr`/`rts` are held low. Outside loopback, `dtr` = bit 0 and `rts` = bit 1.
- R9: Identification bits 3:0 give the highest enabled cause. The causes, from highest to lowest, are: line error 0x6 (enable bit 2, any of status bits 4:1); receive timeout 0xC, or else received data 0x4 (enable bit 0); transmit holding empty 0x2 (enable bit 1); modem change 0x0 (enable bit 3, any of modem bits 3:0). With no cause pending they read 0x1.
- R10: The transmit-empty cause is set by a rising edge of `thr_empty`, or by setting enable bit 1 while `thr_empty` is high. It is cleared by a read of the identification location that reports 0x2, or by a write to the transmit location.
- R11: `irq` is high exactly when an enabled cause is pending and modem-control bit 3 is 1.
- R12: Line-control bits drive `word_len` (1:0), `two_stop` (2), `parity_en` (3), `parity_even` (4), `parity_stick` (5) and `send_break` (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at the closing edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tx_data | output | 8 | Byte handed to the transmitter |
| tx_load | output | 1 | One-cycle transmit strobe |
| rx_data | input | 8 | Head byte of the receive queue |
| rx_pop | output | 1 | One-cycle receive consume strobe |
| rx_ready | input | 1 | Receive data available |
| rx_timeout | input | 1 | Receive character timeout |
| rx_fifo_err | input | 1 | Error held somewhere in the receive queue |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_framing | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break detected event pulse |
| thr_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully idle |
| cts_in | input | 1 | Clear-to-send pin level |
| dsr_in | input | 1 | Data-set-ready pin level |
| ri_in | input | 1 | Ring indicator pin level |
| dcd_in | input | 1 | Carrier detect pin level |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity |
| send_break | output | 1 | Force line to break |
| fifo_en | output | 1 | Queues enabled |
| rx_trig | output | 2 | Receive trigger level code |
| rx_fifo_clr | output | 1 | Receive queue clear pulse |
| tx_fifo_clr | output | 1 | Transmit queue clear pulse |
| dtr | output | 1 | Data-terminal-ready pin |
| rts | output | 1 | Request-to-send pin |
| loopback | output | 1 | Loopback mode active |
| irq | output | 1 | Interrupt request |

## Verification
Random writes with random data to the enable, line-control, modem-control, scratch and divisor locations are mixed with random toggling of the divisor-access bit. A read follows each write and is compared against a bench register model. This separates a wrong remap of addresses 0 and 1 from a wrong field width or mask. Directed sequences then raise the interrupt causes in stacked combinations: error with data, data with timeout, transmit-empty with modem change. Each is retired one at a time, so that a wrong priority order, a wrong clear-on-read or a missing gate on `irq` each shows a distinct wrong code. The modem-status runs toggle each pin, with RI tested on both of its edges, and then repeat in loopback. This exposes wrong level-to-bit placement and a wrong edge polarity for RI.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int IEW = 4;
  localparam int MCW = 5;

  typedef enum logic [AW-1:0] {
    A_DATA = 3'd0, A_IER = 3'd1, A_IIR = 3'd2, A_LCR = 3'd3,
    A_MCR  = 3'd4, A_LSR = 3'd5, A_MSR = 3'd6, A_SCR = 3'd7
  } addr_e;

  typedef enum logic [3:0] {
    ID_MS = 4'h0, ID_NONE = 4'h1, ID_THRE = 4'h2,
    ID_RDA = 4'h4, ID_LS = 4'h6, ID_TO = 4'hC
  } cause_e;
endpackage

// File: rtl/uart_rf_cfg.sv
module uart_rf_cfg
  import uart_rf_pkg::*;
#(
  parameter logic [2*DW-1:0] DIV_INIT = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [IEW-1:0] ier,
  output logic [DW-1:0]  lcr,
  output logic [MCW-1:0] mcr,
  output logic [DW-1:0]  scr,
  output logic [2*DW-1:0] divisor,
  output logic           fifo_en,
  output logic [1:0]     rx_trig,
  output logic           rx_fifo_clr,
  output logic           tx_fifo_clr,
  output logic           tx_load,
  output logic           rx_pop,
  output logic           thre_arm
);
  addr_e a;
  logic  dlab;
  assign a    = addr_e'(addr);
  assign dlab = lcr[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier     <= '0;
      lcr     <= '0;
      mcr     <= '0;
      scr     <= '0;
      divisor <= DIV_INIT;
      fifo_en <= 1'b0;
      rx_trig <= '0;
    end else if (wr_en) begin
      case (a)
        A_DATA: if (dlab) divisor[DW-1:0] <= wdata;
        A_IER:  if (dlab) divisor[2*DW-1:DW] <= wdata;
                else      ier <= wdata[IEW-1:0];
        A_IIR: begin
          fifo_en <= wdata[0];
          rx_trig <= wdata[7:6];
        end
        A_LCR:  lcr <= wdata;
        A_MCR:  mcr <= wdata[MCW-1:0];
        A_SCR:  scr <= wdata;
        default: ;
      endcase
    end
  end

  assign tx_load     = wr_en && (a == A_DATA) && !dlab;
  assign rx_pop      = rd_en && (a == A_DATA) && !dlab;
  assign rx_fifo_clr = wr_en && (a == A_IIR) && wdata[1];
  assign tx_fifo_clr = wr_en && (a == A_IIR) && wdata[2];
  assign thre_arm    = wr_en && (a == A_IER) && !dlab && wdata[1] && !ier[1];

  assert_div_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a == A_DATA && dlab) |=> (divisor[DW-1:0] == $past(wdata)));
  assert_ier_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a == A_IER && dlab) |=> $stable(ier));
  assert_scratch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a == A_SCR) |=> (scr == $past(wdata)));
  assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_clr || tx_fifo_clr) |-> wr_en);
endmodule

// File: rtl/uart_rf_stat.sv
module uart_rf_stat
  import uart_rf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lsr_rd,
  input  logic           msr_rd,
  input  logic           ev_oe,
  input  logic           ev_pe,
  input  logic           ev_fe,
  input  logic           ev_bi,
  input  logic           rx_ready,
  input  logic           thr_empty,
  input  logic           tx_idle,
  input  logic           rx_fifo_err,
  input  logic           cts_in,
  input  logic           dsr_in,
  input  logic           ri_in,
  input  logic           dcd_in,
  input  logic [MCW-1:0] mcr,
  output logic [DW-1:0]  lsr,
  output logic [DW-1:0]  msr
);
  logic [3:0] err;
  logic [3:0] ev;
  logic [3:0] src;
  logic [3:0] lvl;
  logic [3:0] chg;
  logic [3:0] dlt;

  assign ev = {ev_bi, ev_fe, ev_pe, ev_oe};

  always_comb begin
    if (mcr[4]) src = {mcr[3], mcr[2], mcr[0], mcr[1]};
    else        src = {dcd_in, ri_in, dsr_in, cts_in};
  end

  assign chg[0] = src[0] ^ lvl[0];
  assign chg[1] = src[1] ^ lvl[1];
  assign chg[2] = lvl[2] & ~src[2];
  assign chg[3] = src[3] ^ lvl[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= '0;
      lvl <= '0;
      dlt <= '0;
    end else begin
      err <= (lsr_rd ? 4'b0 : err) | ev;
      dlt <= (msr_rd ? 4'b0 : dlt) | chg;
      lvl <= src;
    end
  end

  assign lsr = {rx_fifo_err, tx_idle, thr_empty, err, rx_ready};
  assign msr = {lvl, dlt};

  assert_lsr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && ev == 4'b0) |=> (lsr[4:1] == 4'b0));
  assert_lsr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_rd && err[1]) |=> lsr[2]);
  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && chg == 4'b0) |=> (msr[3:0] == 4'b0));
  assert_ri_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_rd && $rose(msr[6])) |-> (msr[2] == $past(msr[2])));
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IEW-1:0] ier,
  input  logic           ls_any,
  input  logic           rx_ready,
  input  logic           rx_timeout,
  input  logic           thr_empty,
  input  logic           ms_any,
  input  logic           thre_arm,
  input  logic           thr_wr,
  input  logic           iir_rd,
  input  logic           fifo_en,
  input  logic           irq_gate,
  output logic [DW-1:0]  iir,
  output logic           irq
);
  logic   thre_prev;
  logic   thre_pend;
  logic   thre_set;
  logic   thre_clr;
  cause_e id;

  always_comb begin
    if (ier[2] && ls_any)                 id = ID_LS;
    else if (ier[0] && rx_timeout)        id = ID_TO;
    else if (ier[0] && rx_ready)          id = ID_RDA;
    else if (ier[1] && thre_pend)         id = ID_THRE;
    else if (ier[3] && ms_any)            id = ID_MS;
    else                                  id = ID_NONE;
  end

  assign thre_set = thr_empty && (!thre_prev || thre_arm);
  assign thre_clr = thr_wr || (iir_rd && id == ID_THRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_prev <= 1'b1;
      thre_pend <= 1'b0;
    end else begin
      thre_prev <= thr_empty;
      thre_pend <= thre_set || (thre_pend && !thre_clr);
    end
  end

  assign iir = {fifo_en ? 2'b11 : 2'b00, 2'b00, id};
  assign irq = (id != ID_NONE) && irq_gate;

  assert_thre_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == ID_THRE && !thre_set) |=> !thre_pend);
  assert_ls_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && ls_any) |-> (iir[3:0] == ID_LS));
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_gate && !iir[0]));
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter logic [15:0] DIV_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [7:0]  tx_data,
  output logic        tx_load,
  input  logic [7:0]  rx_data,
  output logic        rx_pop,
  input  logic        rx_ready,
  input  logic        rx_timeout,
  input  logic        rx_fifo_err,
  input  logic        err_overrun,
  input  logic        err_parity,
  input  logic        err_framing,
  input  logic        err_break,
  input  logic        thr_empty,
  input  logic        tx_idle,
  input  logic        cts_in,
  input  logic        dsr_in,
  input  logic        ri_in,
  input  logic        dcd_in,
  output logic [15:0] divisor,
  output logic [1:0]  word_len,
  output logic        two_stop,
  output logic        parity_en,
  output logic        parity_even,
  output logic        parity_stick,
  output logic        send_break,
  output logic        fifo_en,
  output logic [1:0]  rx_trig,
  output logic        rx_fifo_clr,
  output logic        tx_fifo_clr,
  output logic        dtr,
  output logic        rts,
  output logic        loopback,
  output logic        irq
);
  addr_e          a;
  logic [IEW-1:0] ier;
  logic [DW-1:0]  lcr;
  logic [MCW-1:0] mcr;
  logic [DW-1:0]  scr;
  logic [DW-1:0]  lsr;
  logic [DW-1:0]  msr;
  logic [DW-1:0]  iir;
  logic           thre_arm;
  logic           dlab;

  assign a    = addr_e'(addr);
  assign dlab = lcr[7];

  uart_rf_cfg #(.DIV_INIT(DIV_INIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ier(ier), .lcr(lcr), .mcr(mcr), .scr(scr),
    .divisor(divisor), .fifo_en(fifo_en), .rx_trig(rx_trig),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .tx_load(tx_load), .rx_pop(rx_pop), .thre_arm(thre_arm)
  );

  uart_rf_stat u_stat (
    .clk(clk), .rst_n(rst_n),
    .lsr_rd(rd_en && a == A_LSR), .msr_rd(rd_en && a == A_MSR),
    .ev_oe(err_overrun), .ev_pe(err_parity), .ev_fe(err_framing),
    .ev_bi(err_break), .rx_ready(rx_ready), .thr_empty(thr_empty),
    .tx_idle(tx_idle), .rx_fifo_err(rx_fifo_err), .cts_in(cts_in),
    .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in), .mcr(mcr),
    .lsr(lsr), .msr(msr)
  );

  uart_rf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ier(ier), .ls_any(|lsr[4:1]),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
    .ms_any(|msr[3:0]), .thre_arm(thre_arm), .thr_wr(tx_load),
    .iir_rd(rd_en && a == A_IIR), .fifo_en(fifo_en), .irq_gate(mcr[3]),
    .iir(iir), .irq(irq)
  );

  always_comb begin
    case (a)
      A_DATA:  rdata = dlab ? divisor[7:0] : rx_data;
      A_IER:   rdata = dlab ? divisor[15:8] : {{(DW-IEW){1'b0}}, ier};
      A_IIR:   rdata = iir;
      A_LCR:   rdata = lcr;
      A_MCR:   rdata = {{(DW-MCW){1'b0}}, mcr};
      A_LSR:   rdata = lsr;
      A_MSR:   rdata = msr;
      default: rdata = scr;
    endcase
  end

  assign tx_data      = wdata;
  assign word_len     = lcr[1:0];
  assign two_stop     = lcr[2];
  assign parity_en    = lcr[3];
  assign parity_even  = lcr[4];
  assign parity_stick = lcr[5];
  assign send_break   = lcr[6];
  assign loopback     = mcr[4];
  assign dtr          = mcr[0] && !mcr[4];
  assign rts          = mcr[1] && !mcr[4];

  assert_loop_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (!dtr && !rts));
  assert_fifo_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && a == A_IIR && fifo_en) |-> (rdata[7:6] == 2'b11));
endmodule

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, tx_data, rx_data = 8'h5A;
  logic tx_load, rx_pop, rx_ready = 0, rx_timeout = 0, rx_fifo_err = 0;
  logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
  logic thr_empty = 1, tx_idle = 1, cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic [15:0] divisor;
  logic [1:0] word_len, rx_trig;
  logic two_stop, parity_en, parity_even, parity_stick, send_break, fifo_en;
  logic rx_fifo_clr, tx_fifo_clr, dtr, rts, loopback, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regfile dut (.*);

  logic [3:0] m_ier; logic [7:0] m_lcr, m_scr; logic [4:0] m_mcr; logic [15:0] m_div;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
    if (a == 1 && m_lcr[7]) m_div[15:8] = d;
    else if (a == 1) m_ier = d[3:0];
    else if (a == 0 && m_lcr[7]) m_div[7:0] = d;
    else if (a == 3) m_lcr = d;
    else if (a == 4) m_mcr = d[4:0];
    else if (a == 7) m_scr = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_div[7:0] : rx_data;
      3'd1: return m_lcr[7] ? m_div[15:8] : {4'h0, m_ier};
      3'd3: return m_lcr;
      3'd4: return {3'b0, m_mcr};
      default: return m_scr;
    endcase
  endfunction

  task automatic pulse_err(input int which);
    @(negedge clk);
    case (which) 0: err_overrun = 1; 1: err_parity = 1; 2: err_framing = 1; default: err_break = 1; endcase
    @(negedge clk);
    err_overrun = 0; err_parity = 0; err_framing = 0; err_break = 0;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_ier = 0; m_lcr = 0; m_scr = 0; m_mcr = 0; m_div = 0;
    void'($urandom(32'd2024));
    idle(3); @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(1, v); chk("R1 ier", v, 0);
    rd(3, v); chk("R1 lcr", v, 0);
    rd(4, v); chk("R1 mcr", v, 0);
    rd(7, v); chk("R1 scr", v, 0);
    rd(2, v); chk("R1 iir", v, 8'h01);
    chk("R1 irq", irq, 0);

    // R12 line fields
    wr(3, 8'h7B);
    chk("R12 fields", {word_len, two_stop, parity_en, parity_even, parity_stick, send_break}, 7'b11_0_1_1_1_1);
    wr(3, 8'h00);

    // R3 divisor access
    wr(3, 8'h80); wr(0, 8'h34); wr(1, 8'h12);
    chk("R3 divisor", divisor, 16'h1234);
    rd(1, v); chk("R3 high read", v, 8'h12);
    wr(3, 8'h00);
    rd(1, v); chk("R3 ier untouched", v, 8'h00);

    // R4 data path strobes
    @(negedge clk); addr = 0; wdata = 8'hA5; wr_en = 1; #1;
    chk("R4 tx_load", {tx_load, tx_data}, {1'b1, 8'hA5});
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk); addr = 0; rd_en = 1; #1;
    chk("R4 rx read", {rx_pop, rdata}, {1'b1, 8'h5A});
    @(posedge clk); #1 rd_en = 0;

    // R5 queue control
    @(negedge clk); addr = 2; wdata = 8'hC7; wr_en = 1; #1;
    chk("R5 clr pulses", {rx_fifo_clr, tx_fifo_clr}, 2'b11);
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk); chk("R5 pulses drop", {rx_fifo_clr, tx_fifo_clr}, 2'b00);
    chk("R5 fifo fields", {fifo_en, rx_trig}, 3'b111);
    rd(2, v); chk("R5 iir fifo bits", v, 8'hC1);
    wr(2, 8'h00); rd(2, v); chk("R5 iir no fifo", v, 8'h01);

    // R6 line status
    pulse_err(1); pulse_err(3);
    rd(5, v); chk("R6 lsr errors", v, 8'h74);
    rd(5, v); chk("R6 lsr cleared", v, 8'h60);

    // R7 modem status
    @(negedge clk); cts_in = 1; idle(2);
    rd(6, v); chk("R7 cts rise", v, 8'h11);
    rd(6, v); chk("R7 delta cleared", v, 8'h10);
    @(negedge clk); ri_in = 1; idle(2);
    rd(6, v); chk("R7 ri rise no delta", v, 8'h50);
    @(negedge clk); ri_in = 0; idle(2);
    rd(6, v); chk("R7 ri trailing", v, 8'h14);
    @(negedge clk); cts_in = 0; idle(2);
    rd(6, v); chk("R7 cts fall", v, 8'h01);
    rd(6, v); chk("R7 idle", v, 8'h00);

    // R8 loopback
    wr(4, 8'h1F); idle(2);
    chk("R8 pins", {loopback, dtr, rts}, 3'b100);
    rd(6, v); chk("R8 loop levels", v, 8'hFB);
    wr(4, 8'h10); idle(2);
    rd(6, v); chk("R8 loop drop", v, 8'h0F);
    wr(4, 8'h03); idle(2);
    chk("R8 normal pins", {loopback, dtr, rts}, 3'b011);
    rd(6, v); chk("R8 pins back", v, 8'h00);

    // R9 / R11 priority
    wr(4, 8'h08); wr(1, 8'h0F);
    pulse_err(0);
    @(negedge clk); rx_ready = 1;
    rd(2, v); chk("R9 line first", v, 8'h06);
    chk("R11 irq on", irq, 1);
    rd(5, v); chk("R6 overrun+data", v, 8'h63);
    rd(2, v); chk("R9 data", v, 8'h04);
    @(negedge clk); rx_timeout = 1;
    rd(2, v); chk("R9 timeout", v, 8'h0C);
    @(negedge clk); rx_timeout = 0; rx_ready = 0; cts_in = 1; idle(2);
    rd(2, v); chk("R9 thre over modem", v, 8'h02);
    rd(2, v); chk("R10 read clears thre", v, 8'h00);
    wr(4, 8'h00);
    chk("R11 gated off", irq, 0);
    wr(4, 8'h08);
    chk("R11 gated on", irq, 1);
    rd(6, v); chk("R7 cts level", v, 8'h11);
    rd(2, v); chk("R9 none", v, 8'h01);
    chk("R11 idle", irq, 0);

    // R10 edge set, write clear
    @(negedge clk); thr_empty = 0; idle(2);
    @(negedge clk); thr_empty = 1; idle(2);
    rd(2, v); chk("R10 edge set", v, 8'h02);
    wr(0, 8'h11);
    rd(2, v); chk("R10 write clears", v, 8'h01);

    // R2 / R3 random register traffic against model
    for (int i = 0; i < 200; i++) begin
      logic [2:0] a;
      int s = $urandom_range(0, 4);
      a = (s == 0) ? 3'd0 : (s == 1) ? 3'd1 : (s == 2) ? 3'd3 : (s == 3) ? 3'd4 : 3'd7;
      wr(a, 8'($urandom));
      s = $urandom_range(0, 4);
      a = (s == 0) ? 3'd0 : (s == 1) ? 3'd1 : (s == 2) ? 3'd3 : (s == 3) ? 3'd4 : 3'd7;
      rd(a, v); chk("R2 random readback", v, exp_rd(a));
      chk("R3 random divisor", divisor, m_div);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1;
    $finish;
  end
endmodule